// File: doc/BRIEF.md
# Dual-Pipe Writeback and Condition-Flag Router

This block sits at the end of a dual-issue execution stage. Each instruction produces two results in the same cycle, one from the add-like pipe and one from the multiply-like pipe. The router decides where each result lands. A result can go to one of two physical register files (A and B) or to one of a small set of accumulators. It can also go to an I/O location that this block does not drive, or nowhere at all. Each pipe's write is gated by its own condition code, which is tested against the block's Z/N/C flags.

A single swap bit exchanges which physical file each pipe targets. When the set-flags bit is raised, the router picks one of the two results and derives new Z/N/C flags from it. Normally that is the add result. It is the mul result when the add operation is a no-op or its condition is "never". The block also watches the read addresses of the incoming instruction. It reports a hazard when that instruction reads a physical register the immediately preceding instruction wrote, because physical registers are not readable in the cycle after a write. Accumulators are exempt.

All outputs are registered, so the effects of an instruction presented before clock edge k are visible after edge k. The condition codes of an instruction are evaluated against the flags as they stand after the previous instruction.

Top module: `dpwb_router`

## Requirements
- R1: While reset is high and in the cycle after it is released, all write enables, the conflict and hazard outputs, and all three flags are zero.
- R2: With the swap bit clear, a passing add-pipe write to address 0–31 appears on file A, and a passing mul-pipe write to 0–31 appears on file B. The address, data and enable are valid one cycle after the instruction.
- R3: With the swap bit set, the add pipe writes file B and the mul pipe writes file A, with the same timing.
- R4: Write addresses 32–37 select accumulators 0–5 (address minus 32). They raise the matching bit of the accumulator enable vector and carry the pipe's result on that accumulator's data lane. They do not touch either physical file.
- R5: Write address 39 is the explicit no-write address. Addresses 38 and 40–63 are other I/O locations that this block does not drive. None of these produces any enable on the block's outputs.
- R6: Condition codes are 3 bits: 0 never, 1 always, 2 Z set, 3 Z clear, 4 N set, 5 N clear, 6 C set, 7 C clear. A pipe whose condition fails against the current flags makes no write, and "never" always suppresses the write.
- R7: When set-flags is high and the add pipe is active, the new Z is set iff the add result is zero, N equals the result's bit 31, and C equals the add carry input.
- R8: When set-flags is high and the add operation is flagged as a no-op or has condition "never", the flags come from the mul result and mul carry instead.
- R9: With set-flags low the flags hold. With set-flags high the flags update even if the selected pipe's own write condition fails.
- R10: If both pipes pass and write the same accumulator, the conflict output pulses one cycle later and that accumulator receives the mul result.
- R11: The hazard output pulses one cycle after an instruction that reads (with its read enable high) file A or file B at a physical address 0–31 that the immediately preceding instruction wrote in that same file. Reads of addresses 32 and above never raise it.
- R12: With the instruction-valid input low, no write, conflict or hazard appears one cycle later and the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| add_res | input | 32 | Add-pipe result |
| add_carry | input | 1 | Add-pipe carry output |
| add_waddr | input | 6 | Add-pipe write address |
| add_cond | input | 3 | Add-pipe condition code |
| add_is_nop | input | 1 | Add operation is a no-op |
| mul_res | input | 32 | Mul-pipe result |
| mul_carry | input | 1 | Mul-pipe carry output |
| mul_waddr | input | 6 | Mul-pipe write address |
| mul_cond | input | 3 | Mul-pipe condition code |
| wswap | input | 1 | Exchange the physical files of the two pipes |
| set_flags | input | 1 | Update Z/N/C from this instruction |
| rd_a_en | input | 1 | Instruction reads file A |
| rd_a_addr | input | 6 | File A read address |
| rd_b_en | input | 1 | Instruction reads file B |
| rd_b_addr | input | 6 | File B read address |
| rfa_we | output | 1 | File A write enable |
| rfa_addr | output | 5 | File A write address |
| rfa_wdata | output | 32 | File A write data |
| rfb_we | output | 1 | File B write enable |
| rfb_addr | output | 5 | File B write address |
| rfb_wdata | output | 32 | File B write data |
| acc_we | output | 6 | Per-accumulator write enable |
| acc_wdata | output | 192 | Accumulator data lanes, lane i at bits 32*i+31:32*i |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry flag |
| wr_conflict | output | 1 | Both pipes wrote one accumulator |
| raw_hazard | output | 1 | Read of a physical register written by the previous instruction |

## Verification
Every result of this block is due exactly one clock edge after its instruction is presented. This covers the file and accumulator writes, the flags, the conflict pulse and the hazard pulse. The bench drives an instruction on the falling edge, lets one rising edge pass, and compares all outputs on the next falling edge, before the following instruction is driven. The bench's reference model evaluates each instruction's conditions against the flags it predicted one instruction earlier. It predicts a hazard from the writes it predicted for the previous instruction, which keeps the one-instruction flag and hazard dependencies aligned with that single-cycle latency.

// File: rtl/dpwb_pkg.sv
package dpwb_pkg;
  typedef enum logic [2:0] {
    CC_NEVER  = 3'd0,
    CC_ALWAYS = 3'd1,
    CC_ZSET   = 3'd2,
    CC_ZCLR   = 3'd3,
    CC_NSET   = 3'd4,
    CC_NCLR   = 3'd5,
    CC_CSET   = 3'd6,
    CC_CCLR   = 3'd7
  } cond_e;

  localparam int PIPE_ADD = 0;
  localparam int PIPE_MUL = 1;
  localparam int NUM_PIPES = 2;
endpackage

// File: rtl/dpwb_cond_eval.sv
module dpwb_cond_eval
  import dpwb_pkg::*;
(
  input  logic [2:0] cond,
  input  logic       fz,
  input  logic       fn,
  input  logic       fc,
  output logic       pass
);
  always_comb begin
    unique case (cond_e'(cond))
      CC_NEVER:  pass = 1'b0;
      CC_ALWAYS: pass = 1'b1;
      CC_ZSET:   pass = fz;
      CC_ZCLR:   pass = ~fz;
      CC_NSET:   pass = fn;
      CC_NCLR:   pass = ~fn;
      CC_CSET:   pass = fc;
      CC_CCLR:   pass = ~fc;
      default:   pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/dpwb_dest_decode.sv
module dpwb_dest_decode #(
  parameter int ADDR_W    = 6,
  parameter int PHYS_REGS = 32,
  parameter int ACC_BASE  = 32,
  parameter int NUM_ACC   = 6
) (
  input  logic [ADDR_W-1:0]  waddr,
  input  logic               en,
  output logic               to_phys,
  output logic [NUM_ACC-1:0] acc_sel
);
  assign to_phys = en && (waddr < ADDR_W'(PHYS_REGS));

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
    assign acc_sel[i] = en && (waddr == ADDR_W'(ACC_BASE + i));
  end
endmodule

// File: rtl/dpwb_flag_sel.sv
module dpwb_flag_sel
  import dpwb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              valid,
  input  logic              set_flags,
  input  logic              add_is_nop,
  input  logic [2:0]        add_cond,
  input  logic [DATA_W-1:0] add_res,
  input  logic              add_carry,
  input  logic [DATA_W-1:0] mul_res,
  input  logic              mul_carry,
  output logic              upd,
  output logic              nz,
  output logic              nn,
  output logic              nc
);
  logic              use_mul;
  logic [DATA_W-1:0] src;

  assign use_mul = add_is_nop || (cond_e'(add_cond) == CC_NEVER);
  assign src     = use_mul ? mul_res : add_res;
  assign upd     = valid && set_flags;
  assign nz      = ~|src;
  assign nn      = src[DATA_W-1];
  assign nc      = use_mul ? mul_carry : add_carry;
endmodule

// File: rtl/dpwb_router.sv
module dpwb_router
  import dpwb_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int PHYS_AW   = 5,
  parameter int ACC_BASE  = 32,
  parameter int NUM_ACC   = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [DATA_W-1:0]         add_res,
  input  logic                      add_carry,
  input  logic [ADDR_W-1:0]         add_waddr,
  input  logic [2:0]                add_cond,
  input  logic                      add_is_nop,
  input  logic [DATA_W-1:0]         mul_res,
  input  logic                      mul_carry,
  input  logic [ADDR_W-1:0]         mul_waddr,
  input  logic [2:0]                mul_cond,
  input  logic                      wswap,
  input  logic                      set_flags,
  input  logic                      rd_a_en,
  input  logic [ADDR_W-1:0]         rd_a_addr,
  input  logic                      rd_b_en,
  input  logic [ADDR_W-1:0]         rd_b_addr,
  output logic                      rfa_we,
  output logic [PHYS_AW-1:0]        rfa_addr,
  output logic [DATA_W-1:0]         rfa_wdata,
  output logic                      rfb_we,
  output logic [PHYS_AW-1:0]        rfb_addr,
  output logic [DATA_W-1:0]         rfb_wdata,
  output logic [NUM_ACC-1:0]        acc_we,
  output logic [NUM_ACC*DATA_W-1:0] acc_wdata,
  output logic                      flag_z,
  output logic                      flag_n,
  output logic                      flag_c,
  output logic                      wr_conflict,
  output logic                      raw_hazard
);
  localparam int PHYS_REGS = 1 << PHYS_AW;

  // per-pipe views, index PIPE_ADD / PIPE_MUL
  logic [ADDR_W-1:0]  waddr_v [NUM_PIPES];
  logic [2:0]         cond_v  [NUM_PIPES];
  logic [DATA_W-1:0]  res_v   [NUM_PIPES];
  logic [NUM_PIPES-1:0] pass_v;
  logic [NUM_PIPES-1:0] phys_v;
  logic [NUM_ACC-1:0] acc_v   [NUM_PIPES];

  assign waddr_v[PIPE_ADD] = add_waddr;
  assign waddr_v[PIPE_MUL] = mul_waddr;
  assign cond_v[PIPE_ADD]  = add_cond;
  assign cond_v[PIPE_MUL]  = mul_cond;
  assign res_v[PIPE_ADD]   = add_res;
  assign res_v[PIPE_MUL]   = mul_res;

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    dpwb_cond_eval u_cond (
      .cond (cond_v[p]),
      .fz   (flag_z),
      .fn   (flag_n),
      .fc   (flag_c),
      .pass (pass_v[p])
    );

    dpwb_dest_decode #(
      .ADDR_W    (ADDR_W),
      .PHYS_REGS (PHYS_REGS),
      .ACC_BASE  (ACC_BASE),
      .NUM_ACC   (NUM_ACC)
    ) u_dec (
      .waddr   (waddr_v[p]),
      .en      (in_valid && pass_v[p]),
      .to_phys (phys_v[p]),
      .acc_sel (acc_v[p])
    );
  end

  // flag source selection
  logic f_upd, f_z, f_n, f_c;

  dpwb_flag_sel #(.DATA_W(DATA_W)) u_flags (
    .valid      (in_valid),
    .set_flags  (set_flags),
    .add_is_nop (add_is_nop),
    .add_cond   (add_cond),
    .add_res    (add_res),
    .add_carry  (add_carry),
    .mul_res    (mul_res),
    .mul_carry  (mul_carry),
    .upd        (f_upd),
    .nz         (f_z),
    .nn         (f_n),
    .nc         (f_c)
  );

  // physical file steering: the swap bit sends each pipe to the opposite file
  logic               a_we_n, b_we_n;
  logic               a_from_mul, b_from_mul;
  logic [PHYS_AW-1:0] a_addr_n, b_addr_n;
  logic [DATA_W-1:0]  a_data_n, b_data_n;

  always_comb begin
    a_from_mul = wswap;
    b_from_mul = ~wswap;
    a_we_n     = a_from_mul ? phys_v[PIPE_MUL] : phys_v[PIPE_ADD];
    b_we_n     = b_from_mul ? phys_v[PIPE_MUL] : phys_v[PIPE_ADD];
    a_addr_n   = a_from_mul ? mul_waddr[PHYS_AW-1:0] : add_waddr[PHYS_AW-1:0];
    b_addr_n   = b_from_mul ? mul_waddr[PHYS_AW-1:0] : add_waddr[PHYS_AW-1:0];
    a_data_n   = a_from_mul ? mul_res : add_res;
    b_data_n   = b_from_mul ? mul_res : add_res;
  end

  // accumulator steering: mul wins a shared target
  logic [NUM_ACC-1:0] acc_we_n;
  logic               conflict_n;

  assign acc_we_n   = acc_v[PIPE_ADD] | acc_v[PIPE_MUL];
  assign conflict_n = |(acc_v[PIPE_ADD] & acc_v[PIPE_MUL]);

  // read-after-write check against the writes now on the outputs
  logic rd_a_phys, rd_b_phys, hazard_n;

  assign rd_a_phys = rd_a_en && (rd_a_addr < ADDR_W'(PHYS_REGS));
  assign rd_b_phys = rd_b_en && (rd_b_addr < ADDR_W'(PHYS_REGS));
  assign hazard_n  = in_valid &&
                     ((rd_a_phys && rfa_we && (rfa_addr == rd_a_addr[PHYS_AW-1:0])) ||
                      (rd_b_phys && rfb_we && (rfb_addr == rd_b_addr[PHYS_AW-1:0])));

  always_ff @(posedge clk) begin
    if (rst) begin
      rfa_we      <= 1'b0;
      rfa_addr    <= '0;
      rfa_wdata   <= '0;
      rfb_we      <= 1'b0;
      rfb_addr    <= '0;
      rfb_wdata   <= '0;
      acc_we      <= '0;
      flag_z      <= 1'b0;
      flag_n      <= 1'b0;
      flag_c      <= 1'b0;
      wr_conflict <= 1'b0;
      raw_hazard  <= 1'b0;
    end else begin
      rfa_we      <= a_we_n;
      rfa_addr    <= a_addr_n;
      rfa_wdata   <= a_data_n;
      rfb_we      <= b_we_n;
      rfb_addr    <= b_addr_n;
      rfb_wdata   <= b_data_n;
      acc_we      <= acc_we_n;
      wr_conflict <= conflict_n;
      raw_hazard  <= hazard_n;
      if (f_upd) begin
        flag_z <= f_z;
        flag_n <= f_n;
        flag_c <= f_c;
      end
    end
  end

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        acc_wdata[i*DATA_W +: DATA_W] <= '0;
      end else if (acc_we_n[i]) begin
        acc_wdata[i*DATA_W +: DATA_W] <= acc_v[PIPE_MUL][i] ? mul_res : add_res;
      end
    end
  end
endmodule

// File: rtl/dpwb_router_chk.sv
module dpwb_router_chk #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6,
  parameter int PHYS_AW  = 5,
  parameter int NUM_ACC  = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [DATA_W-1:0]  add_res,
  input logic [ADDR_W-1:0]  add_waddr,
  input logic [2:0]         add_cond,
  input logic [DATA_W-1:0]  mul_res,
  input logic [ADDR_W-1:0]  mul_waddr,
  input logic [2:0]         mul_cond,
  input logic               wswap,
  input logic               set_flags,
  input logic               rd_a_en,
  input logic               rd_b_en,
  input logic               rfa_we,
  input logic [PHYS_AW-1:0] rfa_addr,
  input logic [DATA_W-1:0]  rfa_wdata,
  input logic               rfb_we,
  input logic [DATA_W-1:0]  rfb_wdata,
  input logic [NUM_ACC-1:0] acc_we,
  input logic               flag_z,
  input logic               flag_n,
  input logic               flag_c,
  input logic               wr_conflict,
  input logic               raw_hazard
);
  localparam int PHYS_REGS = 1 << PHYS_AW;
  localparam logic [ADDR_W-1:0] NOWR = ADDR_W'(39);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rfa_we && !rfb_we && acc_we == '0 && !flag_z && !flag_n &&
                    !flag_c && !wr_conflict && !raw_hazard));

  assert_add_to_a_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && !wswap && add_cond == 3'd1 &&
                          add_waddr < ADDR_W'(PHYS_REGS)))
    |-> (rfa_we && rfa_addr == $past(add_waddr[PHYS_AW-1:0]) && rfa_wdata == $past(add_res)));

  assert_mul_to_a_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && wswap && mul_cond == 3'd1 &&
                          mul_waddr < ADDR_W'(PHYS_REGS)))
    |-> (rfa_we && rfa_wdata == $past(mul_res)));

  assert_mul_to_b_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && !wswap && mul_cond == 3'd1 &&
                          mul_waddr < ADDR_W'(PHYS_REGS)))
    |-> (rfb_we && rfb_wdata == $past(mul_res)));

  assert_nowrite_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(add_waddr == NOWR && mul_waddr == NOWR))
    |-> (!rfa_we && !rfb_we && acc_we == '0));

  assert_never_cond_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(add_cond == 3'd0 && mul_cond == 3'd0))
    |-> (!rfa_we && !rfb_we && acc_we == '0));

  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(set_flags && in_valid))
    |-> ($stable(flag_z) && $stable(flag_n) && $stable(flag_c)));

  assert_conflict_acc_R10: assert property (@(posedge clk) disable iff (rst)
    wr_conflict |-> ($onehot0(acc_we) && acc_we != '0 && $past(add_waddr == mul_waddr)));

  assert_hazard_read_R11: assert property (@(posedge clk) disable iff (rst)
    raw_hazard |-> $past(in_valid && (rd_a_en || rd_b_en)));

  assert_idle_R12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid))
    |-> (!rfa_we && !rfb_we && acc_we == '0 && !wr_conflict && !raw_hazard));
endmodule

bind dpwb_router dpwb_router_chk #(
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .PHYS_AW (PHYS_AW),
  .NUM_ACC (NUM_ACC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .add_res     (add_res),
  .add_waddr   (add_waddr),
  .add_cond    (add_cond),
  .mul_res     (mul_res),
  .mul_waddr   (mul_waddr),
  .mul_cond    (mul_cond),
  .wswap       (wswap),
  .set_flags   (set_flags),
  .rd_a_en     (rd_a_en),
  .rd_b_en     (rd_b_en),
  .rfa_we      (rfa_we),
  .rfa_addr    (rfa_addr),
  .rfa_wdata   (rfa_wdata),
  .rfb_we      (rfb_we),
  .rfb_wdata   (rfb_wdata),
  .acc_we      (acc_we),
  .flag_z      (flag_z),
  .flag_n      (flag_n),
  .flag_c      (flag_c),
  .wr_conflict (wr_conflict),
  .raw_hazard  (raw_hazard)
);

// File: tb/dpwb_router_bench.sv
module dpwb_router_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, in_valid, add_carry, add_is_nop, mul_carry, wswap, set_flags;
  logic        rd_a_en, rd_b_en;
  logic [31:0] add_res, mul_res;
  logic [5:0]  add_waddr, mul_waddr, rd_a_addr, rd_b_addr;
  logic [2:0]  add_cond, mul_cond;
  logic        rfa_we, rfb_we, flag_z, flag_n, flag_c, wr_conflict, raw_hazard;
  logic [4:0]  rfa_addr, rfb_addr;
  logic [31:0] rfa_wdata, rfb_wdata;
  logic [5:0]  acc_we;
  logic [191:0] acc_wdata;

  dpwb_router u_dpwb_router (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .add_res(add_res), .add_carry(add_carry), .add_waddr(add_waddr),
    .add_cond(add_cond), .add_is_nop(add_is_nop),
    .mul_res(mul_res), .mul_carry(mul_carry), .mul_waddr(mul_waddr), .mul_cond(mul_cond),
    .wswap(wswap), .set_flags(set_flags),
    .rd_a_en(rd_a_en), .rd_a_addr(rd_a_addr), .rd_b_en(rd_b_en), .rd_b_addr(rd_b_addr),
    .rfa_we(rfa_we), .rfa_addr(rfa_addr), .rfa_wdata(rfa_wdata),
    .rfb_we(rfb_we), .rfb_addr(rfb_addr), .rfb_wdata(rfb_wdata),
    .acc_we(acc_we), .acc_wdata(acc_wdata),
    .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c),
    .wr_conflict(wr_conflict), .raw_hazard(raw_hazard)
  );

  int ntests = 0;
  int nfail  = 0;
  bit done   = 1'b0;

  // reference model state
  logic m_z, m_n, m_c;
  logic p_awe, p_bwe;
  logic [4:0] p_aaddr, p_baddr;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit cpass(logic [2:0] c, logic z, logic n, logic cy);
    case (c)
      3'd0: return 1'b0;
      3'd1: return 1'b1;
      3'd2: return z;
      3'd3: return !z;
      3'd4: return n;
      3'd5: return !n;
      3'd6: return cy;
      default: return !cy;
    endcase
  endfunction

  task automatic idle_inputs();
    in_valid = 0; add_res = 0; mul_res = 0; add_carry = 0; mul_carry = 0;
    add_waddr = 6'd39; mul_waddr = 6'd39; add_cond = 3'd1; mul_cond = 3'd1;
    add_is_nop = 0; wswap = 0; set_flags = 0;
    rd_a_en = 0; rd_b_en = 0; rd_a_addr = 0; rd_b_addr = 0;
  endtask

  task automatic do_reset();
    rst = 1; idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state while reset is high
    chk("R1", "rfa_we", 32'(rfa_we), 0);
    chk("R1", "rfb_we", 32'(rfb_we), 0);
    chk("R1", "acc_we", 32'(acc_we), 0);
    chk("R1", "flags", {29'd0, flag_z, flag_n, flag_c}, 0);
    chk("R1", "conflict/hazard", {30'd0, wr_conflict, raw_hazard}, 0);
    rst = 0;
    m_z = 0; m_n = 0; m_c = 0; p_awe = 0; p_bwe = 0; p_aaddr = 0; p_baddr = 0;
  endtask

  // drive is already applied (at a negedge); one edge later compare everything
  task automatic step(string tag);
    logic apass, mpass, aph, mph, ewa, ewb, ecf, ehz, usem;
    logic [4:0] eaa, eab;
    logic [31:0] eda, edb;
    logic [5:0] eacc;
    logic [31:0] elane [6];
    logic nz, nn, nc;
    apass = in_valid && cpass(add_cond, m_z, m_n, m_c);
    mpass = in_valid && cpass(mul_cond, m_z, m_n, m_c);
    aph = apass && add_waddr < 32;
    mph = mpass && mul_waddr < 32;
    ewa = 0; ewb = 0; eaa = 0; eab = 0; eda = 0; edb = 0; eacc = 0; ecf = 0;
    for (int i = 0; i < 6; i++) elane[i] = 0;
    if (aph) begin
      if (wswap) begin ewb = 1; eab = add_waddr[4:0]; edb = add_res; end
      else       begin ewa = 1; eaa = add_waddr[4:0]; eda = add_res; end
    end
    if (mph) begin
      if (wswap) begin ewa = 1; eaa = mul_waddr[4:0]; eda = mul_res; end
      else       begin ewb = 1; eab = mul_waddr[4:0]; edb = mul_res; end
    end
    if (apass && add_waddr >= 32 && add_waddr <= 37) begin
      eacc[add_waddr - 32] = 1; elane[add_waddr - 32] = add_res;
    end
    if (mpass && mul_waddr >= 32 && mul_waddr <= 37) begin
      if (eacc[mul_waddr - 32]) ecf = 1;
      eacc[mul_waddr - 32] = 1; elane[mul_waddr - 32] = mul_res;
    end
    ehz = in_valid &&
          ((rd_a_en && rd_a_addr < 32 && p_awe && p_aaddr == rd_a_addr[4:0]) ||
           (rd_b_en && rd_b_addr < 32 && p_bwe && p_baddr == rd_b_addr[4:0]));
    usem = add_is_nop || add_cond == 3'd0;
    nz = usem ? (mul_res == 0) : (add_res == 0);
    nn = usem ? mul_res[31] : add_res[31];
    nc = usem ? mul_carry : add_carry;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "rfa_we", 32'(rfa_we), 32'(ewa));
    if (ewa) begin
      chk(tag, "rfa_addr", 32'(rfa_addr), 32'(eaa));
      chk(tag, "rfa_wdata", rfa_wdata, eda);
    end
    chk(tag, "rfb_we", 32'(rfb_we), 32'(ewb));
    if (ewb) begin
      chk(tag, "rfb_addr", 32'(rfb_addr), 32'(eab));
      chk(tag, "rfb_wdata", rfb_wdata, edb);
    end
    chk(tag, "acc_we", 32'(acc_we), 32'(eacc));
    for (int i = 0; i < 6; i++)
      if (eacc[i]) chk(tag, "acc lane", acc_wdata[i*32 +: 32], elane[i]);
    chk(tag, "wr_conflict", 32'(wr_conflict), 32'(ecf));
    chk(tag, "raw_hazard", 32'(raw_hazard), 32'(ehz));
    if (in_valid && set_flags) begin m_z = nz; m_n = nn; m_c = nc; end
    chk(tag, "flags", {29'd0, flag_z, flag_n, flag_c}, {29'd0, m_z, m_n, m_c});
    p_awe = ewa; p_bwe = ewb; p_aaddr = eaa; p_baddr = eab;
  endtask

  function automatic logic [5:0] rnd_addr();
    case ($urandom % 5)
      0, 1: return 6'($urandom % 32);
      2: return 6'(32 + $urandom % 6);
      3: return 6'd39;
      default: return ($urandom % 2) ? 6'd38 : 6'(40 + $urandom % 24);
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5eed_0042));
    do_reset();

    // R1: first cycle after release
    @(negedge clk);
    chk("R1", "after release we", {30'd0, rfa_we, rfb_we}, 0);

    // R2: no swap
    idle_inputs(); in_valid = 1;
    add_waddr = 6'd5; add_res = 32'hA0A0_0005; mul_waddr = 6'd9; mul_res = 32'hB0B0_0009;
    step("R2");
    // R3: swap
    idle_inputs(); in_valid = 1; wswap = 1;
    add_waddr = 6'd12; add_res = 32'h1111_2222; mul_waddr = 6'd31; mul_res = 32'h3333_4444;
    step("R3");
    // R4: accumulators 1 and 5
    idle_inputs(); in_valid = 1;
    add_waddr = 6'd33; add_res = 32'hACC1_0001; mul_waddr = 6'd37; mul_res = 32'hACC5_0005;
    step("R4");
    // R5: no-write and undriven I/O addresses
    idle_inputs(); in_valid = 1; add_waddr = 6'd39; mul_waddr = 6'd38; add_res = 1; mul_res = 2;
    step("R5");
    idle_inputs(); in_valid = 1; add_waddr = 6'd40; mul_waddr = 6'd63; wswap = 1;
    step("R5");
    // R7: flags from add: zero result, carry set
    idle_inputs(); in_valid = 1; set_flags = 1; add_res = 0; add_carry = 1;
    mul_res = 32'h8000_0000; mul_carry = 0;
    step("R7");
    // R6: Z is now set -> Z-set passes, Z-clear blocks
    idle_inputs(); in_valid = 1; add_cond = 3'd2; add_waddr = 6'd3; add_res = 32'h33;
    mul_cond = 3'd3; mul_waddr = 6'd4; mul_res = 32'h44;
    step("R6");
    idle_inputs(); in_valid = 1; add_cond = 3'd0; mul_cond = 3'd0;
    add_waddr = 6'd1; mul_waddr = 6'd34;
    step("R6");
    // R8: fallback to mul when add is a no-op
    idle_inputs(); in_valid = 1; set_flags = 1; add_is_nop = 1;
    add_res = 0; add_carry = 1; mul_res = 32'h8000_0001; mul_carry = 0;
    step("R8");
    // R8: fallback to mul when add condition is never
    idle_inputs(); in_valid = 1; set_flags = 1; add_cond = 3'd0;
    add_res = 32'h7; add_carry = 0; mul_res = 0; mul_carry = 1;
    step("R8");
    // R9: set_flags low holds flags
    idle_inputs(); in_valid = 1; set_flags = 0; add_res = 32'hFFFF_FFFF; add_carry = 0;
    step("R9");
    // R9: flags update even though the add write condition fails (C set now, use C clear)
    idle_inputs(); in_valid = 1; set_flags = 1; add_cond = 3'd7; add_waddr = 6'd2;
    add_res = 32'h8000_0000; add_carry = 0;
    step("R9");
    // R10: both to accumulator 2
    idle_inputs(); in_valid = 1; add_waddr = 6'd34; mul_waddr = 6'd34;
    add_res = 32'hAAAA_AAAA; mul_res = 32'h5555_5555;
    step("R10");
    // R11: write A7 then read A7
    idle_inputs(); in_valid = 1; add_waddr = 6'd7; add_res = 32'h77;
    step("R11");
    idle_inputs(); in_valid = 1; rd_a_en = 1; rd_a_addr = 6'd7; mul_waddr = 6'd20;
    step("R11");
    // R11: read of B20 written just before -> hazard; read A32 never
    idle_inputs(); in_valid = 1; rd_b_en = 1; rd_b_addr = 6'd20; rd_a_en = 1; rd_a_addr = 6'd32;
    step("R11");
    idle_inputs(); in_valid = 1; add_waddr = 6'd32;
    step("R11");
    idle_inputs(); in_valid = 1; rd_a_en = 1; rd_a_addr = 6'd32;
    step("R11");
    // R12: invalid instruction with everything else active
    idle_inputs(); in_valid = 1; add_waddr = 6'd8;
    step("R12");
    idle_inputs(); in_valid = 0; set_flags = 1; add_waddr = 6'd8; mul_waddr = 6'd35;
    rd_a_en = 1; rd_a_addr = 6'd8; add_res = 0;
    step("R12");
    idle_inputs(); in_valid = 1; rd_a_en = 1; rd_a_addr = 6'd8;
    step("R12");

    // random mix
    for (int k = 0; k < 600; k++) begin
      in_valid   = ($urandom % 8) != 0;
      add_res    = ($urandom % 6 == 0) ? 32'd0 : $urandom;
      mul_res    = ($urandom % 6 == 0) ? 32'd0 : $urandom;
      add_carry  = 1'($urandom);
      mul_carry  = 1'($urandom);
      add_waddr  = rnd_addr();
      mul_waddr  = ($urandom % 6 == 0) ? add_waddr : rnd_addr();
      add_cond   = 3'($urandom);
      mul_cond   = 3'($urandom);
      add_is_nop = ($urandom % 5) == 0;
      wswap      = 1'($urandom);
      set_flags  = 1'($urandom);
      rd_a_en    = 1'($urandom);
      rd_b_en    = 1'($urandom);
      rd_a_addr  = p_awe && ($urandom % 2) ? {1'b0, p_aaddr} : rnd_addr();
      rd_b_addr  = p_bwe && ($urandom % 2) ? {1'b0, p_baddr} : rnd_addr();
      step("rnd R2 R3 R4 R6 R7 R8 R10 R11");
    end

    // reset mid-run returns to the cleared state
    do_reset();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      ntests++; nfail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end
endmodule